// File: doc/BRIEF.md
# Half-Step Clock Pre-Divider with Source Select

This block picks one of up to eight incoming clocks with a 3-bit select and divides the chosen clock by a ratio of (field + 1)/2, where the field has a parameterised width. An odd field gives a whole-number ratio, which is built from rising edges alone. A nonzero even field gives a ratio with a half step, which is built from both edges of the selected clock. Field values 0 and 1 both give a ratio of one, so the chosen clock is forwarded unchanged.

The block sits ahead of a fractional rate stage. Software-side logic drives the select and the field as static levels. The block samples them only on a rising edge of the selected clock that starts a new output cycle. A ratio change, or a change of source, therefore never cuts an output period that is in progress. Source switching is simple: the mux follows the latched select, and there is no glitch-suppression handshake.

Top module: `halfstep_prediv`

## Requirements
- R1: The output is derived from `src_clk[s]`, where s is the latched 3-bit select. A select value at or above NUM_SRC picks source 0.
- R2: With a latched field of 0 or 1, `clk_out` equals the selected clock: the same period and the same high time.
- R3: With an odd latched field f >= 3, let K = (f+1)/2. The output period is K input periods. The output is high for ceil(K/2) input periods, and every output edge falls on a rising edge of the input.
- R4: With an even latched field f >= 2, the output period is (f+1) input half-periods. The output is high for f/2+1 half-periods, and consecutive output periods start on alternating input edge types.
- R5: The select and the field are sampled only on the rising input edge that ends the counter cycle (every output period for odd fields, every second output period for even fields). The period in progress completes with the old settings.
- R6: `rst_n` low asynchronously forces the latched settings to field 0 and source 0, so `clk_out` follows `src_clk[0]` while reset is held.
- R7: Every field value from 0 to 2^DIV_W-1 is honoured. With DIV_W = 4, field 15 divides by 8 and field 14 divides by 7.5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | NUM_SRC | Candidate input clocks, bit i is source i |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 3 | Requested source index |
| div_field | input | DIV_W | Requested divider field, ratio (field+1)/2 |
| clk_out | output | 1 | Pre-divided clock |

## Verification
The hardest case to reach from the ports is a settings change that arrives in the middle of an output period. The change must not alter that period, and for half-step ratios the new period may begin on a falling input edge. The bench aligns itself to a rising edge of `clk_out` under a whole-number ratio, then changes the field, and later the source. It times the following rising edge to confirm that the old period ran to completion. It also sweeps every field value on two sources and a fixed pair of fields on every source, and times both the high phase and the period of two consecutive output cycles. The second cycle covers the falling-edge start of half-step ratios.

// File: rtl/hp_pkg.sv
`timescale 1ns/1ps
package hp_pkg;

   localparam int SEL_W = 3;

   // number of input cycles in one counter cycle for a given field
   function automatic int unsigned hp_span(input int unsigned f);
      if (f <= 1)
         return 1;
      else if ((f % 2) == 1)
         return (f + 1) / 2;
      else
         return f + 1;
   endfunction

   // desired output level in the half-cycle (c, half) of a counter cycle
   function automatic logic hp_level(input int unsigned f,
                                     input int unsigned c,
                                     input logic        half);
      int unsigned k;
      int unsigned p;
      int unsigned t;
      if (f <= 1)
         return 1'b0;
      if ((f % 2) == 1) begin
         k = (f + 1) / 2;
         return (c < (k + 1) / 2);
      end
      p = f + 1;
      t = 2 * c + int'(half);
      if (t >= p)
         t = t - p;
      return (t < (f / 2) + 1);
   endfunction

endpackage

// File: rtl/hp_src_mux.sv
`timescale 1ns/1ps
module hp_src_mux #(
   parameter int NUM_SRC = 8
) (
   input  logic [NUM_SRC-1:0]     src_clk,
   input  logic [hp_pkg::SEL_W-1:0] sel,
   output logic                   clk_sel
);

   generate
      if (NUM_SRC == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^sel;
         assign clk_sel = src_clk[0];
      end else begin : g_multi
         always_comb begin
            clk_sel = src_clk[0];
            for (int i = 1; i < NUM_SRC; i++) begin
               if (sel == hp_pkg::SEL_W'(i))
                  clk_sel = src_clk[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/hp_phase_ctrl.sv
`timescale 1ns/1ps
module hp_phase_ctrl #(
   parameter int DIV_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [DIV_W-1:0]         div_in,
   input  logic [hp_pkg::SEL_W-1:0] sel_in,
   output logic [DIV_W-1:0]         cnt,
   output logic [DIV_W-1:0]         div_act,
   output logic [hp_pkg::SEL_W-1:0] sel_act,
   output logic                     wrap
);
   import hp_pkg::*;

   localparam logic [DIV_W-1:0] CNT_ONE = DIV_W'(1);

   int unsigned span;

   assign span = hp_span(32'(div_act));
   assign wrap = (32'(cnt) == span - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         div_act <= '0;
         sel_act <= '0;
      end else if (wrap) begin
         cnt     <= '0;
         div_act <= div_in;
         sel_act <= sel_in;
      end else begin
         cnt     <= cnt + CNT_ONE;
      end
   end

   // R5: the counter never leaves the span of the latched field
   assert_count_in_span_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) < hp_span(32'(div_act)));

   // R5: settings only move at the end of a counter cycle
   assert_cfg_hold_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> ($stable(div_act) && $stable(sel_act)));

endmodule

// File: rtl/hp_edge_gen.sv
`timescale 1ns/1ps
module hp_edge_gen #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wrap,
   input  logic [DIV_W-1:0] cnt,
   input  logic [DIV_W-1:0] div_act,
   input  logic [DIV_W-1:0] div_in,
   output logic             div_q
);
   import hp_pkg::*;

   localparam logic [DIV_W-1:0] CNT_ONE = DIV_W'(1);

   logic             rise_q;
   logic             fall_q;
   logic [DIV_W-1:0] nxt_cnt;
   logic [DIV_W-1:0] nxt_div;

   assign nxt_cnt = wrap ? '0 : (cnt + CNT_ONE);
   assign nxt_div = wrap ? div_in : div_act;

   // rising-edge half: level of the half-cycle that the coming edge opens
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rise_q <= 1'b0;
      else
         rise_q <= hp_level(32'(nxt_div), 32'(nxt_cnt), 1'b0) ^ fall_q;
   end

   // falling-edge half
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
         fall_q <= 1'b0;
      else
         fall_q <= hp_level(32'(div_act), 32'(cnt), 1'b1) ^ rise_q;
   end

   assign div_q = rise_q ^ fall_q;

   // R3: each output period opens high
   assert_period_starts_high_R3 : assert property (@(negedge clk) disable iff (!rst_n)
      (cnt == '0 && div_act > CNT_ONE) |-> div_q);

   // R4: the last half-cycle before a counter wrap is low
   assert_last_half_low_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && div_act > CNT_ONE) |-> !div_q);

endmodule

// File: rtl/halfstep_prediv.sv
`timescale 1ns/1ps
module halfstep_prediv #(
   parameter int NUM_SRC = 8,
   parameter int DIV_W   = 4
) (
   input  logic [NUM_SRC-1:0] src_clk,
   input  logic               rst_n,
   input  logic [2:0]         src_sel,
   input  logic [DIV_W-1:0]   div_field,
   output logic               clk_out
);

   generate
      if (NUM_SRC < 1 || NUM_SRC > 8) begin : g_bad_src
         $error("NUM_SRC must lie in 1..8");
      end
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("DIV_W must lie in 1..16");
      end
   endgenerate

   localparam logic [DIV_W-1:0] PASS_MAX = DIV_W'(1);

   logic             clk_mux;
   logic [2:0]       sel_act;
   logic [DIV_W-1:0] div_act;
   logic [DIV_W-1:0] cnt;
   logic             wrap;
   logic             div_q;

   hp_src_mux #(.NUM_SRC(NUM_SRC)) u_mux (
      .src_clk (src_clk),
      .sel     (sel_act),
      .clk_sel (clk_mux)
   );

   hp_phase_ctrl #(.DIV_W(DIV_W)) u_phase (
      .clk     (clk_mux),
      .rst_n   (rst_n),
      .div_in  (div_field),
      .sel_in  (src_sel),
      .cnt     (cnt),
      .div_act (div_act),
      .sel_act (sel_act),
      .wrap    (wrap)
   );

   hp_edge_gen #(.DIV_W(DIV_W)) u_edge (
      .clk     (clk_mux),
      .rst_n   (rst_n),
      .wrap    (wrap),
      .cnt     (cnt),
      .div_act (div_act),
      .div_in  (div_field),
      .div_q   (div_q)
   );

   assign clk_out = (div_act <= PASS_MAX) ? clk_mux : div_q;

endmodule

// File: tb/halfstep_prediv_tb.sv
`timescale 1ns/1ps
module halfstep_prediv_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NUM_SRC    = 8;
   localparam int DIV_W      = 4;
   localparam int SETTLE_NS  = 3000;
   localparam int WD_NS      = 1500000;

   wire  [NUM_SRC-1:0] src;
   logic               rst_n;
   logic [2:0]         src_sel;
   logic [DIV_W-1:0]   div_field;
   logic               clk_out;

   int vectors  = 0;
   int miscomp  = 0;
   bit finished = 0;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic sclk;
      initial begin
         sclk = 1'b0;
         #(g);
         forever #((CLK_PERIOD + 4 * g) / 2) sclk = ~sclk;
      end
      assign src[g] = sclk;
   end

   halfstep_prediv #(.NUM_SRC(NUM_SRC), .DIV_W(DIV_W)) u_dut (
      .src_clk   (src),
      .rst_n     (rst_n),
      .src_sel   (src_sel),
      .div_field (div_field),
      .clk_out   (clk_out)
   );

   task automatic chk_t(input string req, input real act, input real exp);
      vectors++;
      if (act - exp > 0.01 || exp - act > 0.01) begin
         miscomp++;
         $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
      end
   endtask

   task automatic chk_b(input string req, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         miscomp++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // arithmetic expectation for period and high time, in ns
   task automatic expect_shape(input int s, input int f, output real per, output real hi);
      real t;
      int  k;
      t = real'(CLK_PERIOD + 4 * s);
      if (f <= 1) begin
         per = t;
         hi  = t / 2.0;
      end else if ((f % 2) == 1) begin
         k   = (f + 1) / 2;
         per = real'(k) * t;
         hi  = real'((k + 1) / 2) * t;
      end else begin
         per = real'(f + 1) * t / 2.0;
         hi  = real'(f / 2 + 1) * t / 2.0;
      end
   endtask

   task automatic measure(input int s, input int f, input string req);
      real per, hi;
      realtime t0, t1, t2, t3, t4;
      src_sel   = 3'(s);
      div_field = DIV_W'(f);
      #(SETTLE_NS);
      expect_shape(s, f, per, hi);
      @(posedge clk_out); t0 = $realtime;
      @(negedge clk_out); t1 = $realtime;
      @(posedge clk_out); t2 = $realtime;
      @(negedge clk_out); t3 = $realtime;
      @(posedge clk_out); t4 = $realtime;
      chk_t($sformatf("%s src%0d f%0d period A", req, s, f), t2 - t0, per);
      chk_t($sformatf("%s src%0d f%0d high A", req, s, f), t1 - t0, hi);
      chk_t($sformatf("%s src%0d f%0d period B", req, s, f), t4 - t2, per);
      chk_t($sformatf("%s src%0d f%0d high B", req, s, f), t3 - t2, hi);
   endtask

   function automatic string req_of(input int f);
      if (f == 15 || f == 14) return "R7";
      if (f <= 1)             return "R2";
      if ((f % 2) == 1)       return "R3";
      return "R4";
   endfunction

   initial begin
      realtime t0, t1;
      rst_n     = 1'b0;
      src_sel   = 3'd3;
      div_field = DIV_W'(5);
      // R6: held in reset, output follows source 0
      #2.5;
      for (int i = 0; i < 8; i++) begin
         chk_b("R6 reset follows src0", clk_out, src[0]);
         #5;
      end
      rst_n = 1'b1;

      // R2 R3 R4 R7: every field on two sources
      for (int f = 0; f < 16; f++) measure(0, f, req_of(f));
      for (int f = 0; f < 16; f++) measure(5, f, req_of(f));
      // R1: each source with one whole and one half-step ratio
      for (int s = 0; s < NUM_SRC; s++) begin
         measure(s, 7, "R1");
         measure(s, 6, "R1");
      end

      // R5: field change mid-period waits for the period end
      measure(0, 9, "R5");
      @(posedge clk_out); t0 = $realtime;
      #1 div_field = DIV_W'(3);
      @(posedge clk_out); t1 = $realtime;
      chk_t("R5 old period kept after field change", t1 - t0, 50.0);
      t0 = t1;
      @(posedge clk_out); t1 = $realtime;
      chk_t("R5 new period after field change", t1 - t0, 20.0);

      // R5: source change mid-period waits for the period end
      measure(0, 9, "R5");
      @(posedge clk_out); t0 = $realtime;
      #1 src_sel = 3'd7;
      @(posedge clk_out); t1 = $realtime;
      chk_t("R5 old period kept after source change", t1 - t0, 50.0);
      @(posedge clk_out); t0 = $realtime;
      @(posedge clk_out); t1 = $realtime;
      chk_t("R5 R1 new source period", t1 - t0, 5.0 * 38.0);

      // R6: asynchronous reset while dividing another source
      measure(3, 9, "R3");
      #7.3 rst_n = 1'b0;
      #0.2;
      for (int i = 0; i < 6; i++) begin
         chk_b("R6 async reset follows src0", clk_out, src[0]);
         #3.7;
      end
      rst_n = 1'b1;

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
   end

   initial begin
      #(WD_NS);
      if (!finished) begin
         miscomp++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
         $finish;
      end
   end

endmodule